// File: doc/BRIEF.md
# Trace Qualification Event Gate

This block decides, cycle by cycle, whether a program-trace recorder may capture. It receives a shared vector of event lines from comparators, counters and other system sources. Three selectors each pick one line from that vector: a window event, a start event and a stop event. Each picked line has its own invert control. Each picked line can also be routed through a two-flop synchronizer when it comes from another clock domain.

A two-bit mode field sets the qualification behaviour. The code `0x` qualifies always, `10` follows the window event level, and `11` opens a capture span on a start edge and closes it on a stop edge. The mode field only matters while the global trace enable is 1. With the enable at 0, the single `qualify` output stays low.

Top module: `trace_qual_gate`

## Requirements
- R1: After reset, `qualify` is 0 and the synchronizer, edge and span state is clear.
- R2: While `trace_en` is 0, `qualify` is 0 for every mode code and every event pattern.
- R3: While `trace_en` is 1 and `mode[1]` is 0 (codes 00 and 01), `qualify` is 1.
- R4: With `trace_en`=1 and mode 10, `qualify` equals the conditioned window event in the same cycle when its synchronizer is off. The conditioned event is `events[win_sel]` XOR `win_inv`.
- R5: Setting an invert bit complements its picked event before edge detection or windowing.
- R6: With a sync bit set, the conditioned event is the XOR-ed picked value delayed by exactly two clock cycles.
- R7: A select value at or above `NEV` picks the constant 0, which is then subject to inversion.
- R8: In mode 11, a rising edge of the conditioned start event makes `qualify` 1 from the next cycle on. A rising edge is the current value 1 with the previous cycle's value 0.
- R9: In mode 11, a rising edge of the conditioned stop event makes `qualify` 0 from the next cycle on. This holds even when a start edge falls in the same cycle.
- R10: In any cycle where `trace_en` is 0, or `mode` differs from its value one cycle earlier, the synchronizer flops, the previous-value flops and the span latch clear at the next edge. After the clear, a conditioned level that is already high counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Global trace enable |
| mode | input | 2 | Qualification mode: 0x always, 10 window, 11 start/stop |
| events | input | NEV | Shared event vector |
| win_sel | input | SELW | Index of the window event |
| win_inv | input | 1 | Invert the window event |
| win_sync | input | 1 | Route the window event through two flops |
| start_sel | input | SELW | Index of the start event |
| start_inv | input | 1 | Invert the start event |
| start_sync | input | 1 | Route the start event through two flops |
| stop_sel | input | SELW | Index of the stop event |
| stop_inv | input | 1 | Invert the stop event |
| stop_sync | input | 1 | Route the stop event through two flops |
| qualify | output | 1 | Capture permitted |

## Verification
Two things can land in the same cycle: a start rising edge and a stop rising edge. The bench forces this in a directed sequence by pointing both selectors at the same event line and raising it. It also reaches the case many times by chance, because random selectors collide and random events toggle. Each time, a reference model built from R8 and R9 must show `qualify` low in the following cycle. Other clashes are judged the same way: a mode change or a drop of the enable that coincides with an edge must follow the clear rule in R10.

// File: rtl/trq_pkg.sv
package trq_pkg;
  typedef enum logic [1:0] {
    QM_FREE_A = 2'b00,
    QM_FREE_B = 2'b01,
    QM_WINDOW = 2'b10,
    QM_SPAN   = 2'b11
  } trq_mode_e;

  localparam int TRQ_NSRC = 3;
  localparam int SRC_WIN  = 0;
  localparam int SRC_STA  = 1;
  localparam int SRC_STO  = 2;

  function automatic logic trq_unqualified(input logic [1:0] m);
    return (m[1] == 1'b0);
  endfunction
endpackage

// File: rtl/trq_event_cond.sv
module trq_event_cond #(
  parameter int NEV  = 16,
  parameter int SELW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NEV-1:0]  events,
  input  logic [SELW-1:0] sel,
  input  logic            inv,
  input  logic            sync_en,
  output logic            cond
);
  function automatic logic pick_line(input logic [NEV-1:0] v, input logic [SELW-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NEV; k++)
      if (int'(s) == k) r = v[k];
    return r;
  endfunction

  logic picked, raw, s1, s2;

  assign picked = pick_line(events, sel);
  assign raw    = picked ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (clr) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  assign cond = sync_en ? s2 : raw;

  assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NEV) |-> (picked == 1'b0));
  assert_sync_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (s2 == $past(s1)));
  assert_clear_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!s1 && !s2));
endmodule

// File: rtl/trq_span_latch.sv
module trq_span_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start_c,
  input  logic stop_c,
  output logic active
);
  logic start_prev, stop_prev;
  logic start_edge, stop_edge;

  assign start_edge = start_c & ~start_prev;
  assign stop_edge  = stop_c & ~stop_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_prev <= 1'b0;
      stop_prev  <= 1'b0;
      active     <= 1'b0;
    end else if (clr) begin
      start_prev <= 1'b0;
      stop_prev  <= 1'b0;
      active     <= 1'b0;
    end else begin
      start_prev <= start_c;
      stop_prev  <= stop_c;
      if (stop_edge)       active <= 1'b0;
      else if (start_edge) active <= 1'b1;
    end
  end

  assert_start_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_edge && !stop_edge && !clr) |=> active);
  assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_edge |=> !active);
  assert_clear_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !active);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !start_edge && !stop_edge) |=> (active == $past(active)));
endmodule

// File: rtl/trace_qual_gate.sv
module trace_qual_gate
  import trq_pkg::*;
#(
  parameter int NEV  = 16,
  parameter int SELW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trace_en,
  input  logic [1:0]      mode,
  input  logic [NEV-1:0]  events,
  input  logic [SELW-1:0] win_sel,
  input  logic            win_inv,
  input  logic            win_sync,
  input  logic [SELW-1:0] start_sel,
  input  logic            start_inv,
  input  logic            start_sync,
  input  logic [SELW-1:0] stop_sel,
  input  logic            stop_inv,
  input  logic            stop_sync,
  output logic            qualify
);
  logic [1:0] mode_q;
  logic       mode_changed, clr;
  logic [SELW-1:0] sel_a  [TRQ_NSRC];
  logic [TRQ_NSRC-1:0] inv_a, sync_a, cond_a;
  logic       span_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'b00;
    else        mode_q <= mode;
  end

  assign mode_changed = (mode != mode_q);
  assign clr          = ~trace_en | mode_changed;

  assign sel_a[SRC_WIN] = win_sel;
  assign sel_a[SRC_STA] = start_sel;
  assign sel_a[SRC_STO] = stop_sel;
  assign inv_a  = {stop_inv, start_inv, win_inv};
  assign sync_a = {stop_sync, start_sync, win_sync};

  for (genvar g = 0; g < TRQ_NSRC; g++) begin : g_src
    trq_event_cond #(.NEV(NEV), .SELW(SELW)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .events  (events),
      .sel     (sel_a[g]),
      .inv     (inv_a[g]),
      .sync_en (sync_a[g]),
      .cond    (cond_a[g])
    );
  end

  trq_span_latch u_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .start_c (cond_a[SRC_STA]),
    .stop_c  (cond_a[SRC_STO]),
    .active  (span_active)
  );

  always_comb begin
    if (!trace_en)                    qualify = 1'b0;
    else if (trq_unqualified(mode))   qualify = 1'b1;
    else if (mode == QM_WINDOW)       qualify = cond_a[SRC_WIN];
    else                              qualify = span_active;
  end

  assert_off_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |-> !qualify);
  assert_free_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && !mode[1]) |-> qualify);
  assert_window_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && mode == 2'b10) |-> (qualify == cond_a[SRC_WIN]));
  always_ff @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!span_active && mode_q == 2'b00);
endmodule

// File: tb/sim_trace_qual_gate.sv
module sim_trace_qual_gate;
  localparam int NEV = 16;
  localparam int SELW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trace_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [NEV-1:0] events = '0;
  logic [SELW-1:0] sel [3];
  logic [2:0] inv = '0, syn = '0;
  logic qualify;

  int n_chk = 0, n_bad = 0;

  // model state
  logic m_s1 [3], m_s2 [3];
  logic m_pst, m_psp, m_lat;
  logic [1:0] m_mq;

  always #10 clk = ~clk;

  trace_qual_gate #(.NEV(NEV), .SELW(SELW)) u0 (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .mode(mode), .events(events),
    .win_sel(sel[0]), .win_inv(inv[0]), .win_sync(syn[0]),
    .start_sel(sel[1]), .start_inv(inv[1]), .start_sync(syn[1]),
    .stop_sel(sel[2]), .stop_inv(inv[2]), .stop_sync(syn[2]),
    .qualify(qualify));

  function automatic logic m_raw(int i);
    logic p;
    p = (int'(sel[i]) < NEV) ? events[sel[i]] : 1'b0;
    return p ^ inv[i];
  endfunction

  function automatic logic m_cond(int i);
    return syn[i] ? m_s2[i] : m_raw(i);
  endfunction

  function automatic logic m_clr();
    return !trace_en || (mode != m_mq);
  endfunction

  function automatic logic m_expect();
    if (!trace_en) return 1'b0;
    if (!mode[1]) return 1'b1;
    if (mode == 2'b10) return m_cond(0);
    return m_lat;
  endfunction

  function automatic string m_tag();
    if (!trace_en) return "R2";
    if (!mode[1]) return "R3";
    if (mode == 2'b10) begin
      if (int'(sel[0]) >= NEV) return "R7";
      if (syn[0]) return "R6";
      if (inv[0]) return "R5";
      return "R4";
    end
    if (mode != m_mq) return "R10";
    if (m_psp == 1'b0 && m_cond(2)) return "R9";
    return "R8";
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 3; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
    m_pst = 0; m_psp = 0; m_lat = 0; m_mq = 2'b00;
  endtask

  task automatic m_update();
    logic c, r [3], cd [3], se, pe;
    c = m_clr();
    for (int i = 0; i < 3; i++) begin r[i] = m_raw(i); cd[i] = m_cond(i); end
    se = cd[1] & ~m_pst;
    pe = cd[2] & ~m_psp;
    for (int i = 0; i < 3; i++) begin
      m_s2[i] = c ? 1'b0 : m_s1[i];
      m_s1[i] = c ? 1'b0 : r[i];
    end
    m_pst = c ? 1'b0 : cd[1];
    m_psp = c ? 1'b0 : cd[2];
    if (c) m_lat = 1'b0;
    else if (pe) m_lat = 1'b0;
    else if (se) m_lat = 1'b1;
    m_mq = mode;
  endtask

  task automatic check(string tag, logic exp);
    n_chk++;
    if (qualify !== exp) begin
      n_bad++;
      $display("FAIL %s: qualify=%b expected=%b at %0t", tag, qualify, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after negedge; check, then cross posedge
  task automatic cycle();
    #5;
    check(m_tag(), m_expect());
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic set_all(logic e, logic [1:0] md, logic [SELW-1:0] a, logic [SELW-1:0] b,
                         logic [SELW-1:0] c, logic [2:0] iv, logic [2:0] sy);
    trace_en = e; mode = md; sel[0] = a; sel[1] = b; sel[2] = c; inv = iv; syn = sy;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    sel[0] = '0; sel[1] = '0; sel[2] = '0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // R3: free mode
    set_all(1, 2'b01, 0, 0, 0, 3'b000, 3'b000);
    cycle(); cycle();
    // R4 / R5 windowed unsynced, inverted
    set_all(1, 2'b10, 8'd3, 0, 0, 3'b000, 3'b000);
    events = 16'h0008; cycle();
    events = 16'h0000; cycle();
    inv = 3'b001; cycle();
    // R7 out of range select, inverted gives 1
    sel[0] = 8'd200; cycle();
    inv = 3'b000; cycle();
    // R6 synchronized window: two cycle delay
    sel[0] = 8'd5; syn = 3'b001; events = 16'h0020;
    cycle(); cycle(); cycle(); cycle();
    // R9 same-cycle start and stop edges: stop wins
    set_all(1, 2'b11, 0, 8'd2, 8'd2, 3'b000, 3'b000);
    events = 16'h0000; cycle(); cycle();
    events = 16'h0004; cycle(); cycle();
    check("R9", 1'b0);
    // R8 start then R9 stop
    sel[2] = 8'd6; events = 16'h0000; cycle();
    events = 16'h0004; cycle(); check("R8", 1'b1);
    events = 16'h0044; cycle(); check("R9", 1'b0);
    // R10 mode change clears span
    events = 16'h0000; cycle(); events = 16'h0004; cycle(); cycle();
    mode = 2'b10; cycle(); mode = 2'b11; cycle(); cycle();
    trace_en = 0; cycle(); trace_en = 1; cycle(); cycle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 24 == 0) begin
        trace_en = ($urandom % 8) != 0;
        mode = 2'($urandom);
        for (int i = 0; i < 3; i++) sel[i] = SELW'($urandom % (NEV + 4));
        inv = 3'($urandom);
        syn = 3'($urandom);
      end
      events = NEV'($urandom);
      if ($urandom % 3 == 0) events = '0;
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: expired expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule